// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Protocol Engine

This block is the slave side of a two-wire serial bus sitting in front of a 256-byte store. It runs on the system clock. It synchronises the oversampled clock and data lines and finds the start and stop conditions on them. It shifts in each byte and decides on every acknowledge. It pulls the data line low only through an open-drain enable output. Reads come straight from the store's asynchronous read port, addressed by the engine's internal pointer. Writes are not performed here. Each accepted data byte is handed to a separate write engine, together with its page address. At the stop condition the engine sends a commit request. The write engine reports back when its write cycle is busy and when the one-time protect register has been set.

Two command codes are decoded. One selects the memory array. The other selects a one-time protect register, which can only be written. While the write engine is busy, the engine refuses every acknowledge. A host can therefore poll the device until the write cycle has finished. Read data and acknowledge bits are launched after the clock falls, following a programmable hold delay counted in system clocks.

Top module: `twm_slave`

## Requirements
- R1: A falling data line while the clock is high (START) begins a command, and a rising data line while the clock is high (STOP) ends it. After a byte it does not acknowledge, the engine ignores all clocking until the next START.
- R2: The first byte after START is the control byte. Bits 7..4 carry the command code, where 1010 selects memory and 0110 selects the protect register. Bits 3..1 must equal the `chipSel` strap. Bit 0 sets the direction, with 1 meaning read. The control byte is acknowledged only when the code is known and the chip-select bits match.
- R3: A 0110 control byte with the read bit set is never acknowledged. A 0110 control byte of any kind is not acknowledged while `protectSet` is high.
- R4: While `wrBusy` is high, no byte of any kind is acknowledged.
- R5: In a memory write, the byte after the control byte loads the address pointer. A repeated START followed by a read control byte then returns the byte at that address.
- R6: Every byte sent to the master advances the pointer by one, and it wraps from FFh to 00h, so a sequential read crosses the end of the array.
- R7: A read started without setting an address returns the byte after the last one read.
- R8: When the master acknowledges a read byte, the engine sends the next one. When the master does not acknowledge, the engine releases the data line and keeps it released until the next START.
- R9: Each acknowledged write data byte raises `wrByteValid` for one cycle, with its byte on `wrByteData` and its pointer on `wrByteAddr`. After the byte, the low 4 pointer bits step by one and wrap inside the 16-byte page, while the upper 4 bits stay unchanged.
- R10: `commitReq` is a one-cycle pulse at STOP. It is sent only if at least one write data byte was accepted since the last START. `wrProtect` is high for protect-register writes.
- R11: After reset the data-line pull-down is off and no strobe is active.
- R12: The pull-down changes no sooner than `HOLD_CYC` clocks after an SCL falling edge has reached the pins, and it only turns on while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullEn | output | 1 | Open-drain enable: 1 pulls the data line low |
| chipSel | input | 3 | Strapped chip-select value |
| memRdAddr | output | 8 | Store read address (the address pointer) |
| memRdData | input | 8 | Store read data, asynchronous |
| wrBusy | input | 1 | Write engine is in its write cycle |
| protectSet | input | 1 | Protect register has been set |
| wrByteValid | output | 1 | One accepted write data byte |
| wrProtect | output | 1 | Current write targets the protect register |
| wrByteAddr | output | 8 | Page address of the write byte |
| wrByteData | output | 8 | Write data byte |
| commitReq | output | 1 | Start the write cycle |

## Verification
The engine is driven by a bit-banged master on a wired-AND data line. The bench mixes random page writes of 1 to 20 bytes at random bases with random sequential reads of random length. Longer writes separate in-page wrap from plain increment. Reads that start near FFh separate a full 8-bit pointer step from the page-only step. Directed sequences cover wrong chip select, unknown codes, protect-register reads, clocking without START, address-only writes that must not commit, and completion polling, which tells apart the acknowledge paths gated by busy and by protect. A probe a few clocks after one SCL fall separates a delayed launch from an immediate one.

// File: rtl/twm_pkg.sv
package twm_pkg;

  localparam logic [3:0] CODE_MEM  = 4'b1010;
  localparam logic [3:0] CODE_PROT = 4'b0110;

  typedef enum logic [1:0] {
    DRV_RELEASE = 2'd0,
    DRV_ACK     = 2'd1,
    DRV_TXBIT   = 2'd2
  } drv_sel_e;

  typedef struct packed {
    logic     rxShift;
    logic     ldPtr;
    logic     incPtr;
    logic     incPage;
    logic     ldTx;
    logic     txShift;
    logic     driveReq;
    drv_sel_e drvSel;
  } ctl_strobe_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sdaBit;
  } bus_evt_t;

endpackage

// File: rtl/twm_datapath.sv
module twm_datapath
  import twm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctl_strobe_t       ctl,
  input  logic [DATA_W-1:0] memRdData,
  output bus_evt_t          evt,
  output logic [DATA_W-1:0] rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaPull
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_comb begin
    evt.rise   = sclS & ~sclPrev;
    evt.fall   = ~sclS & sclPrev;
    evt.start  = sclS & sclPrev & sdaPrev & ~sdaS;
    evt.stop   = sclS & sclPrev & ~sdaPrev & sdaS;
    evt.sdaBit = sdaS;
  end

  // receive shifter and address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptr    <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[DATA_W-2:0], sdaS};
      if (ctl.ldPtr) begin
        ptr <= rxByte[ADDR_W-1:0];
      end else if (ctl.incPtr) begin
        ptr <= ptr + 1'b1;
      end else if (ctl.incPage) begin
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      end
    end
  end

  // transmit shifter
  logic [DATA_W-1:0] txReg, txNext;
  logic driveTarget;

  always_comb begin
    if (ctl.ldTx)         txNext = memRdData;
    else if (ctl.txShift) txNext = {txReg[DATA_W-2:0], 1'b1};
    else                  txNext = txReg;
    unique case (ctl.drvSel)
      DRV_ACK:   driveTarget = 1'b1;
      DRV_TXBIT: driveTarget = ~txNext[DATA_W-1];
      default:   driveTarget = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '1;
    else       txReg <= txNext;
  end

  // launch path: immediate or delayed by HOLD_CYC clocks
  generate
    if (HOLD_CYC == 0) begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             sdaPull <= 1'b0;
        else if (ctl.driveReq) sdaPull <= driveTarget;
      end
    end else begin : g_hold
      localparam int HOLD_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);
      logic              pend, pendVal;
      logic [HOLD_W-1:0] holdCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pend    <= 1'b0;
          pendVal <= 1'b0;
          holdCnt <= '0;
          sdaPull <= 1'b0;
        end else if (ctl.driveReq) begin
          pend    <= 1'b1;
          pendVal <= driveTarget;
          holdCnt <= HOLD_W'(HOLD_CYC);
        end else if (pend) begin
          if (holdCnt == '0) begin
            sdaPull <= pendVal;
            pend    <= 1'b0;
          end else begin
            holdCnt <= holdCnt - 1'b1;
          end
        end
      end
    end
  endgenerate

  AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPull) |-> !sclS) else $error("pull-down began with SCL high"); // R12
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPage && !ctl.ldPtr && !ctl.incPtr) |=>
      ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) else $error("page bits moved"); // R9
  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPtr && !ctl.ldPtr && ptr == '1) |=> ptr == '0) else $error("pointer did not wrap"); // R6

endmodule

// File: rtl/twm_control.sv
module twm_control
  import twm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bus_evt_t          evt,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [2:0]        chipSel,
  input  logic              wrBusy,
  input  logic              protectSet,
  output ctl_strobe_t       ctl,
  output logic              wrByteValid,
  output logic              wrProtect,
  output logic              commitReq
);

  typedef enum logic [2:0] {ST_IDLE, ST_CTRL, ST_ADDR, ST_WDATA, ST_RD} st_e;

  localparam logic [3:0] LAST_BIT = 4'(DATA_W);
  localparam logic [3:0] ACK_SLOT = 4'(DATA_W + 1);

  st_e        st, stN;
  logic [3:0] bitCnt, cntN;
  logic       mAck, mAckN, protSel, protN, hadData, hadN;
  logic       ackOk, codeMem, codeProt, csHit;

  assign codeMem  = rxByte[DATA_W-1 -: 4] == CODE_MEM;
  assign codeProt = rxByte[DATA_W-1 -: 4] == CODE_PROT;
  assign csHit    = rxByte[3:1] == chipSel;

  always_comb begin
    ctl         = '0;
    ctl.drvSel  = DRV_RELEASE;
    stN         = st;
    cntN        = bitCnt;
    mAckN       = mAck;
    protN       = protSel;
    hadN        = hadData;
    wrByteValid = 1'b0;
    commitReq   = 1'b0;
    ackOk       = 1'b0;
    if (evt.start) begin
      stN          = ST_CTRL;
      cntN         = '0;
      hadN         = 1'b0;
      ctl.driveReq = 1'b1;
    end else if (evt.stop) begin
      commitReq    = hadData;
      hadN         = 1'b0;
      stN          = ST_IDLE;
      ctl.driveReq = 1'b1;
    end else if (st == ST_RD) begin
      if (evt.rise) begin
        if (bitCnt == LAST_BIT) mAckN = ~evt.sdaBit;
        if (bitCnt < ACK_SLOT)  cntN  = bitCnt + 4'd1;
      end else if (evt.fall) begin
        if (bitCnt >= 4'd1 && bitCnt < LAST_BIT) begin
          ctl.txShift  = 1'b1;
          ctl.driveReq = 1'b1;
          ctl.drvSel   = DRV_TXBIT;
        end else if (bitCnt == LAST_BIT) begin
          ctl.driveReq = 1'b1;
        end else if (bitCnt == ACK_SLOT) begin
          if (mAck) begin
            ctl.ldTx     = 1'b1;
            ctl.incPtr   = 1'b1;
            ctl.driveReq = 1'b1;
            ctl.drvSel   = DRV_TXBIT;
            cntN         = '0;
          end else begin
            stN = ST_IDLE;
          end
        end
      end
    end else if (st != ST_IDLE) begin
      if (evt.rise && bitCnt < LAST_BIT) begin
        ctl.rxShift = 1'b1;
        cntN        = bitCnt + 4'd1;
      end else if (evt.fall && bitCnt == LAST_BIT) begin
        if (st == ST_CTRL)
          ackOk = !wrBusy && csHit && (codeMem || (codeProt && !rxByte[0] && !protectSet));
        else
          ackOk = !wrBusy;
        ctl.driveReq = 1'b1;
        if (ackOk) begin
          ctl.drvSel = DRV_ACK;
          cntN       = ACK_SLOT;
          unique case (st)
            ST_CTRL:  protN = codeProt;
            ST_ADDR:  ctl.ldPtr = !protSel;
            default: begin
              wrByteValid = 1'b1;
              ctl.incPage = !protSel;
              hadN        = 1'b1;
            end
          endcase
        end else begin
          stN = ST_IDLE;
        end
      end else if (evt.fall && bitCnt == ACK_SLOT) begin
        cntN         = '0;
        ctl.driveReq = 1'b1;
        if (st == ST_CTRL && rxByte[0]) begin
          stN        = ST_RD;
          ctl.ldTx   = 1'b1;
          ctl.incPtr = 1'b1;
          ctl.drvSel = DRV_TXBIT;
        end else if (st == ST_CTRL) begin
          stN = ST_ADDR;
        end else begin
          stN = ST_WDATA;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      bitCnt  <= '0;
      mAck    <= 1'b0;
      protSel <= 1'b0;
      hadData <= 1'b0;
    end else begin
      st      <= stN;
      bitCnt  <= cntN;
      mAck    <= mAckN;
      protSel <= protN;
      hadData <= hadN;
    end
  end

  assign wrProtect = protSel;

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driveReq && ctl.drvSel == DRV_ACK) |-> !wrBusy) else $error("ack while busy"); // R4
  AST_PROT_READ_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CTRL && codeProt && rxByte[0]) |-> !(ctl.drvSel == DRV_ACK)) else $error("protect read acked"); // R3
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |=> !commitReq) else $error("commit longer than a cycle"); // R10
  AST_WRBYTE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid |-> !commitReq) else $error("byte and commit together"); // R10

endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int HOLD_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullEn,
  input  logic [2:0] chipSel,
  output logic [7:0] memRdAddr,
  input  logic [7:0] memRdData,
  input  logic       wrBusy,
  input  logic       protectSet,
  output logic       wrByteValid,
  output logic       wrProtect,
  output logic [7:0] wrByteAddr,
  output logic [7:0] wrByteData,
  output logic       commitReq
);

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;

  ctl_strobe_t       ctl;
  bus_evt_t          evt;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptr;

  twm_datapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .memRdData(memRdData), .evt(evt), .rxByte(rxByte), .ptr(ptr), .sdaPull(sdaPullEn)
  );

  twm_control #(.DATA_W(DATA_W)) control_i (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .chipSel(chipSel),
    .wrBusy(wrBusy), .protectSet(protectSet), .ctl(ctl),
    .wrByteValid(wrByteValid), .wrProtect(wrProtect), .commitReq(commitReq)
  );

  assign memRdAddr  = ptr;
  assign wrByteAddr = ptr;
  assign wrByteData = rxByte;

endmodule

// File: tb/twm_slave_tb_top.sv
module twm_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int HOLD       = 3;
  localparam int BUSY_CYC   = 2500;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullEn, wrBusy = 1'b0, protectSet = 1'b0;
  logic wrByteValid, wrProtect, commitReq;
  logic [7:0] memRdAddr, memRdData, wrByteAddr, wrByteData;
  logic sdaLine;

  logic [7:0] mem [256];
  logic [7:0] stg [256];
  logic       stgV [256];
  logic       protPend = 1'b0;
  int         busyCnt = 0;
  int         commitCount = 0;

  logic [7:0] refMem [256];

  int checks = 0, errors = 0;
  logic probeLaunch = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaLine   = sdaM & ~sdaPullEn;
  assign memRdData = mem[memRdAddr];

  twm_slave #(.HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullEn(sdaPullEn),
    .chipSel(CS), .memRdAddr(memRdAddr), .memRdData(memRdData), .wrBusy(wrBusy),
    .protectSet(protectSet), .wrByteValid(wrByteValid), .wrProtect(wrProtect),
    .wrByteAddr(wrByteAddr), .wrByteData(wrByteData), .commitReq(commitReq)
  );

  // write engine model
  always @(posedge clk) begin
    if (wrByteValid) begin
      if (wrProtect) protPend <= 1'b1;
      else begin
        stg[wrByteAddr]  <= wrByteData;
        stgV[wrByteAddr] <= 1'b1;
      end
    end
    if (commitReq) begin
      commitCount <= commitCount + 1;
      busyCnt     <= BUSY_CYC;
      wrBusy      <= 1'b1;
    end else if (wrBusy) begin
      if (busyCnt == 0) begin
        wrBusy <= 1'b0;
        for (int i = 0; i < 256; i++) begin
          if (stgV[i]) mem[i] <= stg[i];
          stgV[i] <= 1'b0;
        end
        if (protPend) protectSet <= 1'b1;
        protPend <= 1'b0;
      end else begin
        busyCnt <= busyCnt - 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mkCtrl(input logic [3:0] code, input logic [2:0] cs, input logic rw);
    return {code, cs, rw};
  endfunction

  function automatic logic expCtrlAck(input logic [7:0] c, input logic busy, input logic prot);
    logic known;
    known = (c[7:4] == 4'b1010) || (c[7:4] == 4'b0110 && !c[0] && !prot);
    return !busy && (c[3:1] == CS) && known;
  endfunction

  function automatic logic [7:0] pageAddr(input logic [7:0] base, input int k);
    return {base[7:4], 4'(base[3:0] + k)};
  endfunction

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    waitQ(Q); sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(2*Q);
    sdaM = 1'b0; waitQ(2*Q); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitQ(Q); sdaM = 1'b0; waitQ(Q); sclM = 1'b1; waitQ(2*Q);
    sdaM = 1'b1; waitQ(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q); sdaM = b[i]; waitQ(Q); sclM = 1'b1; waitQ(2*Q); sclM = 1'b0;
    end
    if (probeLaunch) begin
      waitQ(HOLD);
      chk(sdaPullEn == 1'b0, "R12 launch held", sdaPullEn, 0);
    end
    waitQ(probeLaunch ? Q - HOLD : Q); sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q);
    ack = ~sdaLine;
    waitQ(Q); sclM = 1'b0;
  endtask

  task automatic recvByte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q); sdaM = 1'b1; waitQ(Q); sclM = 1'b1; waitQ(Q); b[i] = sdaLine; waitQ(Q); sclM = 1'b0;
    end
    waitQ(Q); sdaM = ~mack; waitQ(Q); sclM = 1'b1; waitQ(2*Q); sclM = 1'b0;
  endtask

  task automatic ctrlAckCheck(input logic [7:0] c, input string tag);
    logic ack;
    logic exp;
    exp = expCtrlAck(c, wrBusy, protectSet);
    sendByte(c, ack);
    chk(ack == exp, tag, ack, exp);
  endtask

  task automatic pollDone(output int nacks);
    logic ack;
    nacks = 0;
    for (int g = 0; g < 40; g++) begin
      busStart();
      sendByte(mkCtrl(4'b1010, CS, 1'b0), ack);
      busStop();
      if (ack) begin
        chk(wrBusy == 1'b0, "R4 ack only when idle", wrBusy, 0);
        return;
      end
      nacks++;
    end
    chk(1'b0, "R4 poll never acked", nacks, 0);
  endtask

  task automatic doWrite(input logic [7:0] base, input int n);
    logic ack;
    logic [7:0] d;
    int nacks;
    busStart();
    ctrlAckCheck(mkCtrl(4'b1010, CS, 1'b0), "R2 write control ack");
    sendByte(base, ack);
    chk(ack, "R5 address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, ack);
      chk(ack, "R9 data ack", ack, 1);
      refMem[pageAddr(base, k)] = d;
    end
    busStop();
    pollDone(nacks);
    chk(nacks > 0, "R4 busy refuses poll", nacks, 1);
  endtask

  task automatic doRead(input logic [7:0] addr, input int n, input logic setAddr, input string tag);
    logic ack;
    logic [7:0] b;
    logic [7:0] a;
    busStart();
    if (setAddr) begin
      sendByte(mkCtrl(4'b1010, CS, 1'b0), ack);
      sendByte(addr, ack);
      chk(ack, "R5 address ack", ack, 1);
      busStart();
    end
    sendByte(mkCtrl(4'b1010, CS, 1'b1), ack);
    chk(ack, "R2 read control ack", ack, 1);
    a = addr;
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b);
      chk(b == refMem[a], tag, b, refMem[a]);
      a = a + 8'd1;
    end
    waitQ(Q);
    chk(sdaPullEn == 1'b0, "R8 released after nack", sdaPullEn, 0);
    busStop();
  endtask

  initial begin
    logic ack;
    int nacks;
    int cc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
      stgV[i] = 1'b0;
    end
    waitQ(5);
    chk(sdaPullEn == 1'b0, "R11 pull off in reset", sdaPullEn, 0);
    rstN = 1'b1;
    waitQ(5);
    chk(sdaPullEn == 1'b0 && commitReq == 1'b0 && wrByteValid == 1'b0, "R11 idle after reset", sdaPullEn, 0);

    // chip select, code and framing
    busStart();
    ctrlAckCheck(mkCtrl(4'b1010, 3'b001, 1'b0), "R2 wrong chip select");
    sendByte(mkCtrl(4'b1010, CS, 1'b0), ack);
    chk(!ack, "R1 ignored without START", ack, 0);
    busStop();
    busStart();
    ctrlAckCheck(mkCtrl(4'b1111, CS, 1'b0), "R2 unknown code");
    busStop();
    busStart();
    ctrlAckCheck(mkCtrl(4'b0110, CS, 1'b1), "R3 protect read refused");
    busStop();

    // launch delay probe on a matching control byte
    busStart();
    probeLaunch = 1'b1;
    sendByte(mkCtrl(4'b1010, CS, 1'b0), ack);
    probeLaunch = 1'b0;
    chk(ack, "R12 ack after delay", ack, 1);
    busStop();

    // address-only write, random read, current read
    cc = commitCount;
    doRead(8'h30, 1, 1'b1, "R5 random read");
    chk(commitCount == cc, "R10 no commit without data", commitCount, cc);
    doRead(8'h31, 1, 1'b0, "R7 current address read");

    // wrap across the end of the array
    doRead(8'hFE, 4, 1'b1, "R6 sequential wrap");

    // page rollover
    cc = commitCount;
    doWrite(8'h45, 18);
    chk(commitCount == cc + 1, "R10 one commit per write", commitCount, cc + 1);
    doRead(8'h40, 16, 1'b1, "R9 page rollover");

    // random traffic
    for (int it = 0; it < 5; it++) begin
      logic [7:0] base;
      base = 8'($urandom);
      doWrite(base, 1 + int'($urandom % 20));
      doRead(8'($urandom), 1 + int'($urandom % 6), 1'b1, "R6 random sequential read");
    end

    // protect register
    busStart();
    ctrlAckCheck(mkCtrl(4'b0110, CS, 1'b0), "R3 protect write accepted");
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    busStop();
    chk(wrProtect == 1'b1, "R10 protect target flagged", wrProtect, 1);
    pollDone(nacks);
    chk(protectSet == 1'b1, "R3 protect register set", protectSet, 1);
    busStart();
    ctrlAckCheck(mkCtrl(4'b0110, CS, 1'b0), "R3 refused once set");
    busStop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule